// File: doc/BRIEF.md
# FFT Stage Permutation Word Generator

This block produces, for one radix-2 FFT stage at a time, the two bit-select configuration words that a permuted vector register needs while a transform of length 2^K runs entirely inside registers. The data word reorders the element read counter so that the two operands of every butterfly leave the data registers back to back. In stage i the partners are 2^i elements apart. The twiddle word maps the same counter onto a register that holds interleaved real and imaginary parts of the largest set of roots of unity. Some of its fields are forced to constant zero, so the smaller root sets of the early stages come out replicated. No memory is read to produce them.

A sequencer drives a stage index together with a one-cycle request strobe. One clock later the block presents both packed words with a valid pulse, ready to be copied into the permutation registers of the data and coefficient vectors. An index that names no stage of the transform raises an error flag and yields the identity mapping on both words.

Top module: `stage_perm_gen`

## Requirements
- R1: While reset is high and in the first cycle after it, `valid_o` and `err_o` are 0 and both words hold the identity mapping (field j equals j).
- R2: `valid_o` is 1 in exactly the cycle after a cycle in which `req_i` was sampled high, and 0 otherwise.
- R3: Each word has K fields of FW = clog2(K+2) bits. The field for output address bit j sits at bits [j*FW +: FW]. A field value m < K selects counter bit m, the value K means constant 1, and the value K+1 means constant 0.
- R4: In the data word for stage i, every field j with j > i holds j.
- R5: In the data word for stage i, field i holds 0, so counter bit 0 drives address bit i.
- R6: In the data word for stage i, every field j with j < i holds j+1.
- R7: In the twiddle word for every valid stage, field 0 holds 0, so the lowest counter bit always picks the real or imaginary half.
- R8: In the twiddle word for stage i, with t = K-1-i, field j (j >= 1) holds j-t when j > t and holds K+1 (constant 0) otherwise.
- R9: A request with stage index >= K gives `err_o` = 1 and the identity mapping on both words. An in-range request gives `err_o` = 0.
- R10: In cycles with no request the words and `err_o` keep their last values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 1 | Request strobe for one stage |
| stage_i | input | SW = clog2(K+1) | Stage index to generate |
| valid_o | output | 1 | Words updated by the previous cycle's request |
| err_o | output | 1 | Last request named a stage outside 0..K-1 |
| shift_word_o | output | K*FW | Packed data-register bit-select word |
| twid_word_o | output | K*FW | Packed twiddle-register bit-select word |

## Verification
Every result of this block is due exactly one clock edge after the request that produced it: the valid pulse, the error flag and both words. The bench drives a request on a falling edge and compares the outputs on the next falling edge, after the single register stage has loaded. It then checks one more falling edge later that the valid pulse has ended and the words have stayed put. Back-to-back requests are checked the same way, with each result sampled in the cycle that follows its own strobe.

// File: rtl/stage_perm_pkg.sv
package stage_perm_pkg;

    // Source kind of one output address bit
    typedef enum logic [1:0] {
        SRC_CNT  = 2'd0,
        SRC_ONE  = 2'd1,
        SRC_ZERO = 2'd2
    } src_kind_e;

    typedef struct packed {
        src_kind_e   kind;
        logic [15:0] idx;
    } bit_sel_t;

    // Field code: counter bit index, K for constant 1, K+1 for constant 0
    function automatic int unsigned encode_field(bit_sel_t sel, int unsigned k);
        case (sel.kind)
            SRC_CNT: return int'(sel.idx);
            SRC_ONE: return k;
            default: return k + 1;
        endcase
    endfunction

    // Data-register selection for output bit j at stage i
    function automatic bit_sel_t shift_sel(int j, int i);
        bit_sel_t s;
        s.kind = SRC_CNT;
        if (j > i)       s.idx = 16'(j);
        else if (j == i) s.idx = 16'd0;
        else             s.idx = 16'(j + 1);
        return s;
    endfunction

    // Twiddle-register selection for output bit j at stage i
    function automatic bit_sel_t twiddle_sel(int j, int i, int k);
        bit_sel_t s;
        int t;
        t = k - 1 - i;
        s.kind = SRC_CNT;
        s.idx  = 16'd0;
        if (j != 0) begin
            if (j > t) s.idx = 16'(j - t);
            else       s.kind = SRC_ZERO;
        end
        return s;
    endfunction

endpackage

// File: rtl/shift_word_gen.sv
module shift_word_gen
    import stage_perm_pkg::*;
#(
    parameter int K  = 8,
    parameter int FW = 4,
    parameter int SW = 4
) (
    input  logic [SW-1:0]   stage_i,
    output logic [K*FW-1:0] word_o
);
    for (genvar j = 0; j < K; j++) begin : g_fld
        assign word_o[j*FW +: FW] =
            FW'(encode_field(shift_sel(j, int'(stage_i)), K));
    end
endmodule

// File: rtl/twiddle_word_gen.sv
module twiddle_word_gen
    import stage_perm_pkg::*;
#(
    parameter int K  = 8,
    parameter int FW = 4,
    parameter int SW = 4
) (
    input  logic [SW-1:0]   stage_i,
    output logic [K*FW-1:0] word_o
);
    for (genvar j = 0; j < K; j++) begin : g_fld
        assign word_o[j*FW +: FW] =
            FW'(encode_field(twiddle_sel(j, int'(stage_i), K), K));
    end
endmodule

// File: rtl/stage_perm_gen.sv
module stage_perm_gen
    import stage_perm_pkg::*;
#(
    parameter int K  = 8,
    localparam int FW = $clog2(K + 2),
    localparam int SW = $clog2(K + 1),
    localparam int WW = K * FW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_i,
    input  logic [SW-1:0] stage_i,
    output logic          valid_o,
    output logic          err_o,
    output logic [WW-1:0] shift_word_o,
    output logic [WW-1:0] twid_word_o
);
    logic [WW-1:0] ident_w;
    logic [WW-1:0] shift_w;
    logic [WW-1:0] twid_w;
    logic          in_range;

    for (genvar j = 0; j < K; j++) begin : g_ident
        assign ident_w[j*FW +: FW] = FW'(j);
    end

    assign in_range = (int'(stage_i) < K);

    shift_word_gen #(.K(K), .FW(FW), .SW(SW)) u_shift (
        .stage_i (stage_i),
        .word_o  (shift_w)
    );

    twiddle_word_gen #(.K(K), .FW(FW), .SW(SW)) u_twid (
        .stage_i (stage_i),
        .word_o  (twid_w)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_o      <= 1'b0;
            err_o        <= 1'b0;
            shift_word_o <= ident_w;
            twid_word_o  <= ident_w;
        end else begin
            valid_o <= req_i;
            if (req_i) begin
                err_o        <= !in_range;
                shift_word_o <= in_range ? shift_w : ident_w;
                twid_word_o  <= in_range ? twid_w  : ident_w;
            end
        end
    end

    // R2
    valid_after_req_chk: assert property (@(posedge clk) disable iff (rst)
        req_i |=> valid_o);

    // R2
    no_spurious_valid_chk: assert property (@(posedge clk) disable iff (rst)
        !req_i |=> !valid_o);

    // R10
    hold_words_chk: assert property (@(posedge clk) disable iff (rst)
        !req_i |=> ($stable(shift_word_o) && $stable(twid_word_o) && $stable(err_o)));

    // R7
    twid_low_field_chk: assert property (@(posedge clk) disable iff (rst)
        (valid_o && !err_o) |-> (twid_word_o[FW-1:0] == '0));

    // R9
    err_identity_chk: assert property (@(posedge clk) disable iff (rst)
        (valid_o && err_o) |-> (shift_word_o == twid_word_o));

endmodule

// File: tb/stage_perm_gen_tb.sv
`timescale 1ns/1ps
module stage_perm_gen_tb;
    localparam int K = 8;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_i;
    logic [3:0]  stage_i;
    logic        valid_o;
    logic        err_o;
    logic [31:0] shift_word_o;
    logic [31:0] twid_word_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    stage_perm_gen #(.K(K)) u_dut (
        .clk          (clk),
        .rst          (rst),
        .req_i        (req_i),
        .stage_i      (stage_i),
        .valid_o      (valid_o),
        .err_o        (err_o),
        .shift_word_o (shift_word_o),
        .twid_word_o  (twid_word_o)
    );

    // {stage, err, data word, twiddle word}; nibble j = field j, 9 = constant 0
    localparam logic [68:0] VEC [10] = '{
        {4'd0,  1'b0, 32'h76543210, 32'h99999990},
        {4'd1,  1'b0, 32'h76543201, 32'h19999990},
        {4'd2,  1'b0, 32'h76543021, 32'h21999990},
        {4'd3,  1'b0, 32'h76540321, 32'h32199990},
        {4'd4,  1'b0, 32'h76504321, 32'h43219990},
        {4'd5,  1'b0, 32'h76054321, 32'h54321990},
        {4'd6,  1'b0, 32'h70654321, 32'h65432190},
        {4'd7,  1'b0, 32'h07654321, 32'h76543210},
        {4'd8,  1'b1, 32'h76543210, 32'h76543210},
        {4'd15, 1'b1, 32'h76543210, 32'h76543210}
    };

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 5000) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected<=5000", cycles);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; req_i = 1'b0; stage_i = 4'd0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 valid", 32'(valid_o), 32'd0);
        check("R1 err", 32'(err_o), 32'd0);
        check("R1 data", shift_word_o, 32'h76543210);
        check("R1 twid", twid_word_o, 32'h76543210);
        rst = 1'b0;
        @(negedge clk);
        check("R1 after release data", shift_word_o, 32'h76543210);

        // R3 R4 R5 R6 R7 R8 R9: table walk
        for (int n = 0; n < 10; n++) begin
            req_i = 1'b1; stage_i = VEC[n][68:65];
            @(negedge clk);
            req_i = 1'b0;
            check("R2 valid", 32'(valid_o), 32'd1);
            check("R9 err", 32'(err_o), 32'(VEC[n][64]));
            check("R4 R5 R6 data", shift_word_o, VEC[n][63:32]);
            check("R7 R8 twid", twid_word_o, VEC[n][31:0]);
            stage_i = 4'd3;
            @(negedge clk);
            // R10: no request, words hold
            check("R2 valid drop", 32'(valid_o), 32'd0);
            check("R10 data hold", shift_word_o, VEC[n][63:32]);
            check("R10 twid hold", twid_word_o, VEC[n][31:0]);
        end

        // R2: back-to-back requests
        req_i = 1'b1; stage_i = 4'd2;
        @(negedge clk);
        stage_i = 4'd12;
        check("R2 b2b first data", shift_word_o, 32'h76543021);
        @(negedge clk);
        stage_i = 4'd5;
        check("R9 b2b err", 32'(err_o), 32'd1);
        check("R9 b2b twid", twid_word_o, 32'h76543210);
        @(negedge clk);
        req_i = 1'b0;
        check("R9 err clears", 32'(err_o), 32'd0);
        check("R8 b2b twid", twid_word_o, 32'h54321990);
        check("R2 b2b valid", 32'(valid_o), 32'd1);
        @(negedge clk);
        check("R10 err hold", 32'(err_o), 32'd0);

        // R1: reset mid-run restores identity
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R1 re-reset twid", twid_word_o, 32'h76543210);
        check("R1 re-reset valid", 32'(valid_o), 32'd0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule